// File: doc/BRIEF.md
# Almost-empty status bus arbiter

Several expanded FIFO devices share one narrow status bus that reports, for a single device at a time, which of its queues are almost empty. Each device carries one instance of this block. The bus has one bit per queue. Bit n reflects queue n, so queue 3 reports on bit 3, and a bit at 1 means that queue is almost empty. The queue logic supplies those per-queue bits to the block, already synchronized to the read clock.

The reader picks which device owns the bus. It presents a device address together with a one-cycle status strobe on the read clock. Every instance compares the address with its own device ID. On the edge that samples the strobe, every instance stops driving, including the current owner and including an instance that is selected again. On the following edge, only the instance whose ID matched begins to drive. Because of this one-cycle gap, two devices never drive at once. The tri-state pins are modelled as an output enable plus a data vector that reads zero while the enable is low.

Top module: `ae_status_bus_arb`

## Requirements
- R1: After reset, `bus_oe` is 0 and `bus_data` is all zeros, and they stay so until a strobe selects this device.
- R2: A strobe sampled with `sel_addr` equal to `dev_id`, followed by a cycle with no strobe, raises `bus_oe` on the next rising edge. The enable is therefore high one full cycle after the sampling edge.
- R3: Any strobe, whatever its address, clears `bus_oe` on the rising edge that samples it. An owner that is handing over is therefore off for the whole cycle before the new owner drives.
- R4: A strobe whose address differs from `dev_id` leaves the device not driving until a later matching strobe.
- R5: While driving, bit n of `bus_data` equals the value `qstat[n]` had at the previous rising edge (1 = queue n almost empty; queue 3 on bit 3).
- R6: While `bus_oe` is 0, `bus_data` is all zeros.
- R7: Without a strobe, an owner keeps driving, and changes on `sel_addr` are ignored.
- R8: With strobes on consecutive cycles, only the last one decides the owner.
- R9: Across instances with distinct IDs on one bus, at most one `bus_oe` is high in any cycle.

Note: the "Width" column below shows the default values NQ = 4 and AW = 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Read clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| qstat | input | NQ | Per-queue almost-empty status, 1 = almost empty |
| strobe | input | 1 | Status-bus selection strobe |
| sel_addr | input | AW | Device address sampled with the strobe |
| dev_id | input | AW | This device's own address |
| bus_data | output | NQ | Status value for the shared bus, zero while not driving |
| bus_oe | output | 1 | High while this device drives the bus |

## Verification
Suppose the pending-selection flag is wrong. A device would then either drive one cycle too early, overlapping the old owner, or never take the bus. Either fault shows on `bus_oe` within two edges of the strobe. A stale registered status shows on `bus_data` on the cycle after `qstat` changes. The bench wires three instances together and watches the shared enables every cycle, so an overlap anywhere is caught in the cycle it happens.

// File: rtl/ae_status_bus_arb.sv
module ae_status_bus_arb #(
  parameter int NQ = 4,
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NQ-1:0] qstat,
  input  logic          strobe,
  input  logic [AW-1:0] sel_addr,
  input  logic [AW-1:0] dev_id,
  output logic [NQ-1:0] bus_data,
  output logic          bus_oe
);

  logic          hit;
  logic          pend_q;
  logic          oe_q;
  logic [NQ-1:0] stat_q;

  assign hit = (sel_addr == dev_id);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      oe_q   <= 1'b0;
      stat_q <= '0;
    end else begin
      stat_q <= qstat;
      if (strobe) begin
        oe_q   <= 1'b0;
        pend_q <= hit;
      end else begin
        oe_q   <= oe_q | pend_q;
        pend_q <= 1'b0;
      end
    end
  end

  assign bus_oe   = oe_q;
  assign bus_data = oe_q ? stat_q : '0;

endmodule

module ae_status_bus_arb_chk #(
  parameter int NQ = 4,
  parameter int AW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic [NQ-1:0] qstat,
  input logic          strobe,
  input logic [AW-1:0] sel_addr,
  input logic [AW-1:0] dev_id,
  input logic [NQ-1:0] bus_data,
  input logic          bus_oe
);

  logic [1:0] age;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) age <= 2'd0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  AST_IDLE_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd0) |-> !bus_oe); // R1

  AST_SELECT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (age != 2'd0 && $past(strobe) && $past(sel_addr) == $past(dev_id) && !strobe) |=> bus_oe); // R2

  AST_RELEASE_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |=> !bus_oe); // R3

  AST_NO_SPURIOUS_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 2'd2 && $rose(bus_oe)) |->
      ($past(strobe, 2) && $past(sel_addr, 2) == $past(dev_id, 2) && !$past(strobe))); // R4

  AST_DATA_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
    (age != 2'd0 && bus_oe) |-> bus_data == $past(qstat)); // R5

  AST_HOLD_OWNERSHIP: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_oe && !strobe) |=> bus_oe); // R7

endmodule

bind ae_status_bus_arb ae_status_bus_arb_chk #(.NQ(NQ), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .qstat(qstat), .strobe(strobe),
  .sel_addr(sel_addr), .dev_id(dev_id), .bus_data(bus_data), .bus_oe(bus_oe)
);

// File: tb/ae_status_bus_arb_tb.sv
`timescale 1ns/1ps
module ae_status_bus_arb_tb;
  localparam int NQ = 4;
  localparam int AW = 3;

  logic clk = 1'b0;
  logic rst_n;
  logic strobe;
  logic [AW-1:0] sel_addr;
  logic [NQ-1:0] qs5, qs3, qs4;
  logic [NQ-1:0] d5, d3, d4, bus;
  logic oe5, oe3, oe4;
  int n_chk = 0;
  int n_bad = 0;
  int clash = 0;

  always #4 clk = ~clk;

  ae_status_bus_arb #(.NQ(NQ), .AW(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .qstat(qs5), .strobe(strobe), .sel_addr(sel_addr),
    .dev_id(3'd5), .bus_data(d5), .bus_oe(oe5));
  ae_status_bus_arb #(.NQ(NQ), .AW(AW)) u_dev3 (
    .clk(clk), .rst_n(rst_n), .qstat(qs3), .strobe(strobe), .sel_addr(sel_addr),
    .dev_id(3'd3), .bus_data(d3), .bus_oe(oe3));
  ae_status_bus_arb #(.NQ(NQ), .AW(AW)) u_dev4 (
    .clk(clk), .rst_n(rst_n), .qstat(qs4), .strobe(strobe), .sel_addr(sel_addr),
    .dev_id(3'd4), .bus_data(d4), .bus_oe(oe4));

  assign bus = d5 | d3 | d4;

  always @(negedge clk)
    if (rst_n && $countones({oe5, oe3, oe4}) > 1) clash++;

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic select(input logic [AW-1:0] a);
    @(negedge clk); strobe = 1'b1; sel_addr = a;
    @(negedge clk); strobe = 1'b0;
  endtask

  task automatic t_reset;
    chk({29'd0, oe5, oe3, oe4}, 32'd0, "R1 enables after reset");
    chk(bus, 4'h0, "R1 R6 bus after reset");
    @(negedge clk);
    chk({29'd0, oe5, oe3, oe4}, 32'd0, "R1 still idle");
  endtask

  task automatic t_select_dut;
    qs5 = 4'b0110;
    select(3'd5);
    chk({29'd0, oe5, oe3, oe4}, 32'd0, "R3 gap after strobe");
    @(negedge clk);
    chk({29'd0, oe5, oe3, oe4}, 32'b100, "R2 selected device drives");
    chk(bus, 4'b0110, "R5 bus shows status");
  endtask

  task automatic t_status_follow;
    qs5 = 4'b1000;
    @(negedge clk);
    chk(bus, 4'b1000, "R5 queue 3 on bit 3");
    qs5 = 4'b0001;
    @(negedge clk);
    chk(bus, 4'b0001, "R5 queue 0 on bit 0");
  endtask

  task automatic t_ignore_addr;
    sel_addr = 3'd4;
    repeat (3) @(negedge clk);
    chk({31'd0, oe5}, 32'd1, "R7 owner kept without strobe");
    chk({31'd0, oe4}, 32'd0, "R7 address ignored");
  endtask

  task automatic t_handover;
    qs4 = 4'b1010;
    select(3'd4);
    chk({29'd0, oe5, oe3, oe4}, 32'd0, "R3 old owner released");
    chk(bus, 4'h0, "R6 undriven bus is zero");
    @(negedge clk);
    chk({29'd0, oe5, oe3, oe4}, 32'b001, "R2 new owner drives");
    chk(d5, 4'h0, "R6 released device data zero");
    chk(bus, 4'b1010, "R5 new owner status");
  endtask

  task automatic t_unmatched;
    select(3'd7);
    chk({31'd0, oe4}, 32'd0, "R3 release on unmatched strobe");
    repeat (3) @(negedge clk);
    chk({29'd0, oe5, oe3, oe4}, 32'd0, "R4 no device takes bus");
  endtask

  task automatic t_back2back;
    @(negedge clk); strobe = 1'b1; sel_addr = 3'd5;
    @(negedge clk); sel_addr = 3'd3;
    @(negedge clk); strobe = 1'b0;
    chk({29'd0, oe5, oe3, oe4}, 32'd0, "R8 gap after burst");
    @(negedge clk);
    chk({29'd0, oe5, oe3, oe4}, 32'b010, "R8 last strobe wins");
    @(negedge clk);
    chk({31'd0, oe5}, 32'd0, "R8 earlier target stays off");
  endtask

  initial begin
    #200000;
    n_bad++;
    $display("FAIL watchdog: actual running expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; strobe = 1'b0; sel_addr = '0;
    qs5 = '0; qs3 = 4'b0101; qs4 = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_select_dut();
    t_status_follow();
    t_ignore_addr();
    t_handover();
    t_unmatched();
    t_back2back();
    chk(clash, 0, "R9 no overlapping enables");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule